// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an internal single-word request port and an external asynchronous static RAM of 128K words by 8 bits. A request carries a direction, a 17-bit word address and, for a write, one data byte. It is taken over a valid/ready handshake. The controller then drives the RAM address, a pair of chip selects (one active low, one active high), an active-low output enable and an active-low write enable. It holds them for enough system clock cycles to meet the RAM's access, pulse and setup minima. A read returns its byte with a one-cycle response pulse.

Every interval is a nanosecond parameter that is converted to clock cycles by rounding up. The conversion uses the clock period parameter. The bidirectional data bus appears as three separate signals: data to the RAM, data from the RAM and an output-enable for the pad. The controller drives the bus only around the write pulse. After every read it leaves the bus idle for a turnaround interval, so that the RAM's output drivers have turned off before anything else can drive the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, req_ready is 1, mem_ce_n is 1, mem_ce is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and rsp_valid is 0. A reset that arrives in the middle of a transaction returns the outputs to these values at once.
- R2: req_ready is 1 only while the controller is idle. It falls in the cycle after a request is accepted and stays 0 until that transaction is complete, so only one request is in flight.
- R3: During a read, for 9 cycles at the default timing (max of 70 ns address access, 70 ns cycle and 35 ns output-enable access, at 8 ns per cycle), the outputs hold these values: mem_ce_n=0, mem_ce=1, mem_oe_n=0, mem_we_n=1, mem_dq_oe=0 and mem_addr equal to the requested address.
- R4: The read byte is sampled at the end of that window. It appears on rsp_rdata together with a single-cycle rsp_valid pulse, in the same cycle that the selects and output enable are released.
- R5: After a read, the controller waits 4 turnaround cycles (25 ns to high impedance, rounded up) with both selects inactive and mem_oe_n high. Only then does req_ready return to 1.
- R6: A write holds mem_we_n low for 8 cycles at the default timing (max of the 50 ns pulse, 60 ns address-to-end and 60 ns select-to-end of write, and 30 ns data setup). Throughout the pulse, mem_dq_oe is 1, mem_dq_out equals the request data, mem_oe_n is 1, the selects are active and mem_addr is stable.
- R7: After mem_we_n rises, the write data, address and selects are held for one more cycle. In the cycle after that, the bus is released (mem_dq_oe=0), the selects turn inactive and req_ready returns to 1. The whole write takes 9 cycles, which is at least 70 ns.
- R8: mem_dq_oe is 1 only while mem_we_n is low or in the single hold cycle that follows. mem_oe_n and mem_we_n are never low together.
- R9: req_valid has no effect while req_ready is 0. A request held valid during a busy interval is accepted only at the first idle cycle, and its strobes start in the following cycle.
- R10: rsp_valid is never asserted for a write transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the RAM |

## Verification
Two events can meet in a single clock: the end of a busy interval, when req_ready rises, and a request that is already waiting on req_valid. The bench provokes this by raising req_valid for a write while a read is still in flight, and keeping it high through the read's capture and its turnaround. It then checks that mem_we_n stays high until req_ready has been 1 for exactly one cycle, and that the write strobe starts in the cycle after that. A bench RAM model returns bytes only while the read strobes are valid and stores them on the rising write enable, so written data is confirmed by reading it back.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WP_NS       = 50,
  parameter int T_AW_NS       = 60,
  parameter int T_DW_NS       = 30,
  parameter int T_WC_NS       = 70,
  parameter int T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int P      = CLK_PERIOD_NS;
  localparam int C_RC   = (T_RC_NS + P - 1) / P;
  localparam int C_AA   = (T_AA_NS + P - 1) / P;
  localparam int C_OE   = (T_OE_NS + P - 1) / P;
  localparam int C_WP   = (T_WP_NS + P - 1) / P;
  localparam int C_AW   = (T_AW_NS + P - 1) / P;
  localparam int C_DW   = (T_DW_NS + P - 1) / P;
  localparam int C_WC   = (T_WC_NS + P - 1) / P;
  localparam int C_HZ   = (T_HZ_NS + P - 1) / P;
  localparam int RD_A   = (C_AA > C_OE) ? C_AA : C_OE;
  localparam int RD_B   = (RD_A > C_RC) ? RD_A : C_RC;
  localparam int RD_CYC = (RD_B > 1) ? RD_B : 1;
  localparam int WP_A   = (C_WP > C_AW) ? C_WP : C_AW;
  localparam int WP_B   = (WP_A > C_DW) ? WP_A : C_DW;
  localparam int WP_CYC = (WP_B > 1) ? WP_B : 1;
  localparam int HD_CYC = (C_WC > WP_CYC + 1) ? (C_WC - WP_CYC) : 1;
  localparam int HZ_CYC = (C_HZ > 1) ? C_HZ : 1;
  localparam int MX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MX_B   = (HD_CYC > HZ_CYC) ? HD_CYC : HZ_CYC;
  localparam int MX_CYC = (MX_A > MX_B) ? MX_A : MX_B;
  localparam int CNT_W  = $clog2(MX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD_WAIT, S_WR_PULSE, S_WR_HOLD, S_TURN} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             sel;

  wire cnt_done = (cnt == '0);

  assign req_ready = (state == S_IDLE);
  assign mem_ce_n  = ~sel;
  assign mem_ce    = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sel        <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          sel      <= 1'b1;
          if (req_write) begin
            mem_we_n   <= 1'b0;
            mem_dq_oe  <= 1'b1;
            mem_dq_out <= req_wdata;
            cnt        <= CNT_W'(WP_CYC - 1);
            state      <= S_WR_PULSE;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            state    <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: if (cnt_done) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          mem_oe_n  <= 1'b1;
          sel       <= 1'b0;
          cnt       <= CNT_W'(HZ_CYC - 1);
          state     <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_WR_PULSE: if (cnt_done) begin
          mem_we_n <= 1'b1;
          cnt      <= CNT_W'(HD_CYC - 1);
          state    <= S_WR_HOLD;
        end else cnt <= cnt - 1'b1;
        S_WR_HOLD: if (cnt_done) begin
          sel       <= 1'b0;
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt_done) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out
);
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R8
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n))); // R8
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce)); // R6
  AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R6
  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R7
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid, ce_n, ce, oe_n, we_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_out, dq_in;
  logic [16:0] maddr;
  logic [7:0]  ram [int];
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(maddr),
    .mem_ce_n(ce_n), .mem_ce(ce), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in));

  always_comb begin
    if (!ce_n && ce && !oe_n && we_n && !dq_oe)
      dq_in = ram.exists(int'(maddr)) ? ram[int'(maddr)] : 8'h00;
    else
      dq_in = 8'hA5;
  end

  always @(posedge we_n)
    if (rst_n && !ce_n && ce && dq_oe) ram[int'(maddr)] = dq_out;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wait_ready;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic rd_body(input logic [16:0] a, input logic [7:0] exp);
    for (int j = 0; j < 9; j++) begin
      chk("R3 ce_n", ce_n, 0);   chk("R3 ce", ce, 1);
      chk("R3 oe_n", oe_n, 0);   chk("R3 we_n", we_n, 1);
      chk("R3 dq_oe", dq_oe, 0); chk("R3 addr", maddr, a);
      chk("R4 early rsp", rsp_valid, 0); chk("R2 ready busy", req_ready, 0);
      @(negedge clk);
    end
    chk("R4 rsp_valid", rsp_valid, 1); chk("R4 rdata", rsp_rdata, exp);
    chk("R5 oe_n off", oe_n, 1); chk("R5 ce_n off", ce_n, 1); chk("R5 ready", req_ready, 0);
    for (int j = 10; j < 13; j++) begin
      @(negedge clk);
      chk("R5 turnaround ready", req_ready, 0); chk("R5 oe_n", oe_n, 1);
      chk("R5 ce", ce, 0); chk("R4 pulse", rsp_valid, 0); chk("R9 no write", we_n, 1);
    end
    @(negedge clk);
    chk("R5 ready back", req_ready, 1);
  endtask

  task automatic wr_body(input logic [16:0] a, input logic [7:0] d);
    for (int j = 0; j < 8; j++) begin
      chk("R6 we_n", we_n, 0);   chk("R6 dq_oe", dq_oe, 1);
      chk("R6 dq_out", dq_out, d); chk("R6 oe_n", oe_n, 1);
      chk("R6 ce_n", ce_n, 0);   chk("R6 addr", maddr, a);
      chk("R10 no rsp", rsp_valid, 0);
      @(negedge clk);
    end
    chk("R7 we_n up", we_n, 1); chk("R7 hold dq_oe", dq_oe, 1);
    chk("R7 hold data", dq_out, d); chk("R7 hold addr", maddr, a);
    chk("R7 hold ce", ce, 1); chk("R10 no rsp", rsp_valid, 0);
    @(negedge clk);
    chk("R7 released", dq_oe, 0); chk("R7 ce_n off", ce_n, 1);
    chk("R7 ready", req_ready, 1); chk("R10 no rsp", rsp_valid, 0);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    wait_ready;
    @(negedge clk);
    req_valid = 1'b0;
    rd_body(a, exp);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    wait_ready;
    @(negedge clk);
    req_valid = 1'b0;
    wr_body(a, d);
  endtask

  task automatic test_reset;
    chk("R1 ready", req_ready, 1); chk("R1 ce_n", ce_n, 1); chk("R1 ce", ce, 0);
    chk("R1 oe_n", oe_n, 1); chk("R1 we_n", we_n, 1); chk("R1 dq_oe", dq_oe, 0);
    chk("R1 rsp", rsp_valid, 0);
  endtask

  task automatic test_held_request;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
    wait_ready;
    @(negedge clk);
    req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h99;
    rd_body(17'h1FFFF, 8'hC3);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 write starts after idle", we_n, 0);
    wr_body(17'h00777, 8'h99);
  endtask

  task automatic test_mid_reset;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'h11;
    wait_ready;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    do_write(17'h1FFFF, 8'hC3);
    do_write(17'h00000, 8'h3C);
    do_write(17'h0ABCD, 8'h7E);
    do_read(17'h00000, 8'h3C);
    do_read(17'h0ABCD, 8'h7E);
    do_read(17'h12345, 8'h00);
    test_held_request();
    do_read(17'h00777, 8'h99);
    test_mid_reset();
    do_read(17'h00042, 8'h00);
    summary();
    $finish;
  end
endmodule